// File: doc/BRIEF.md
# Audio Stream Control State Machine

This block is the control core for one direction (transmit or receive) of an audio serial port. It takes configure commands and trigger commands and keeps one of five states. It tracks the block queue with a count of queued sample blocks and a word counter inside the block currently in transfer. It turns the serializer on and off and answers each command with a one-cycle accept or reject pulse. The serializer datapath and the storage of the blocks are outside the block. The serializer reports each word it moves on `word_tick`, and the buffer manager hands over whole blocks on the `blk_valid`/`blk_ready` stream.

The block stream follows valid/ready rules. A block is taken on a cycle where both signals are high. `blk_ready` drops when the queue is full or the state does not allow queuing. A producer that sees `blk_ready` low keeps `blk_valid` high until it rises again or withdraws the block. In the transmit variant a queued block holds data waiting to be sent. In the receive variant it is an empty buffer waiting to be filled. `word_tick` cannot be held off. A tick that arrives with no block in the queue is an underrun (transmit) or an overrun (receive).

Every command is judged against the state register in the cycle it is presented. Its result appears one cycle later. If an accepted DROP meets a tick in the same cycle, the DROP wins. An underrun in the same cycle as an accepted STOP or DRAIN wins over the STOP or DRAIN. The parameter `DEPTH` must be at least 2.

Top module: `audio_stream_ctrl`

## Requirements
- R1: After reset, `state` is NOT_READY (encoding 0), `ser_en` is 0, `q_count` is 0 and neither `cmd_ack` nor `cmd_err` is high. State encodings: NOT_READY=0, READY=1, RUNNING=2, STOPPING=3, ERROR=4.
- R2: CONFIG (code 0) is accepted only in NOT_READY or READY. If `cmd_rate_zero` is 1, the state goes to NOT_READY and the queue empties. Otherwise the state goes to READY and the block length is latched from `cmd_blk_words`. A CONFIG with a non-zero rate and a block length of 0 is rejected.
- R3: Each command gives exactly one of `cmd_ack` or `cmd_err`, one cycle later, for one cycle. An illegal command, or an unused code (6 or 7), leaves the state unchanged.
- R4: START (code 1) is legal only in READY and moves to RUNNING with `ser_en` high. The transmit variant also needs `q_count` of at least 1. The receive variant does not.
- R5: `blk_ready` is high only in READY or RUNNING with `q_count` below `DEPTH`. Each handshake adds one to `q_count`.
- R6: While `ser_en` is high, each `word_tick` advances the word counter. The tick that completes a block of the latched length raises `blk_done` for one cycle and takes one from `q_count`. Ticks while `ser_en` is low are ignored.
- R7: STOP (code 2) is legal only in RUNNING and moves to STOPPING. When the current block completes, the state becomes READY and the remaining blocks stay queued. A later START continues from the start of the next block.
- R8: DRAIN (code 3) is legal only in RUNNING and moves to STOPPING. The transmit variant returns to READY only when the last queued block completes. The receive variant returns to READY at the end of the current block, as STOP does.
- R9: DROP (code 4) is legal in every state except NOT_READY. It moves to READY, clears `q_count` and the word counter, and turns `ser_en` off.
- R10: PREPARE (code 5) is legal only in ERROR and moves to READY.
- R11: A `word_tick` with `ser_en` high and `q_count` 0 moves the state to ERROR and turns `ser_en` off. An accepted DROP in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 3 | Command: 0 CONFIG, 1 START, 2 STOP, 3 DRAIN, 4 DROP, 5 PREPARE |
| cmd_rate_zero | input | 1 | With CONFIG: the configured frame rate is zero |
| cmd_blk_words | input | LEN_W | With CONFIG: block length in words (frames times words per frame) |
| cmd_ack | output | 1 | Previous cycle's command accepted |
| cmd_err | output | 1 | Previous cycle's command rejected |
| blk_valid | input | 1 | A block is offered to the queue |
| blk_ready | output | 1 | The queue takes an offered block |
| word_tick | input | 1 | The serializer moved one word |
| ser_en | output | 1 | Serializer enable |
| blk_done | output | 1 | A block completed in the previous cycle |
| q_count | output | $clog2(DEPTH+1) | Number of queued blocks |
| state | output | 3 | Current state encoding |

## Verification
The bench builds two copies side by side with `DEPTH` 4 and `LEN_W` 8. One copy has `IS_TX` set and the other has it cleared, and both receive the same stimulus. With a depth of 4, a few handshakes are enough to fill the queue, so the full-queue back-pressure and the refused extra block can be reached. Short blocks of 2 and 3 words bring block boundaries within a few ticks. They also let the bench show that DROP clears a partly counted block. With both variants present, the bench can compare DRAIN against STOP and START with an empty queue against START with a filled one.

// File: rtl/asc_pkg.sv
package asc_pkg;
  typedef enum logic [2:0] {
    ST_NOT_READY = 3'd0,
    ST_READY     = 3'd1,
    ST_RUNNING   = 3'd2,
    ST_STOPPING  = 3'd3,
    ST_ERROR     = 3'd4
  } asc_state_e;

  localparam logic [2:0] OP_CONFIG  = 3'd0;
  localparam logic [2:0] OP_START   = 3'd1;
  localparam logic [2:0] OP_STOP    = 3'd2;
  localparam logic [2:0] OP_DRAIN   = 3'd3;
  localparam logic [2:0] OP_DROP    = 3'd4;
  localparam logic [2:0] OP_PREPARE = 3'd5;
endpackage

// File: rtl/asc_cmd_decode.sv
module asc_cmd_decode
  import asc_pkg::*;
#(
  parameter bit IS_TX = 1'b1
) (
  input  asc_state_e state,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       rate_zero,
  input  logic       len_zero,
  input  logic       q_nonempty,
  output logic       accept,
  output logic       reject,
  output asc_state_e next_state
);
  logic legal;

  always_comb begin
    legal      = 1'b0;
    next_state = state;
    case (cmd_code)
      OP_CONFIG: begin
        if ((state == ST_NOT_READY || state == ST_READY) && (rate_zero || !len_zero)) begin
          legal      = 1'b1;
          next_state = rate_zero ? ST_NOT_READY : ST_READY;
        end
      end
      OP_START: begin
        if (state == ST_READY && (!IS_TX || q_nonempty)) begin
          legal      = 1'b1;
          next_state = ST_RUNNING;
        end
      end
      OP_STOP, OP_DRAIN: begin
        if (state == ST_RUNNING) begin
          legal      = 1'b1;
          next_state = ST_STOPPING;
        end
      end
      OP_DROP: begin
        if (state != ST_NOT_READY) begin
          legal      = 1'b1;
          next_state = ST_READY;
        end
      end
      OP_PREPARE: begin
        if (state == ST_ERROR) begin
          legal      = 1'b1;
          next_state = ST_READY;
        end
      end
      default: legal = 1'b0;
    endcase
  end

  assign accept = cmd_valid & legal;
  assign reject = cmd_valid & ~legal;
endmodule

// File: rtl/asc_block_tracker.sv
module asc_block_tracker #(
  parameter int DEPTH = 4,
  parameter int LEN_W = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic             tick,
  input  logic             load_len,
  input  logic [LEN_W-1:0] len_in,
  output logic [CNT_W-1:0] count,
  output logic             underrun,
  output logic             done_ev
);
  logic [LEN_W-1:0] blk_len;
  logic [LEN_W-1:0] word_cnt;
  logic             tick_ok;
  logic             last_word;

  assign tick_ok   = tick && (count != '0);
  assign underrun  = tick && (count == '0);
  assign last_word = (word_cnt == blk_len - LEN_W'(1));
  assign done_ev   = tick_ok && last_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_len <= LEN_W'(1);
    end else if (load_len) begin
      blk_len <= len_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      word_cnt <= '0;
    end else if (tick_ok) begin
      word_cnt <= last_word ? '0 : word_cnt + LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count <= '0;
    end else begin
      count <= count + CNT_W'(push) - CNT_W'(done_ev);
    end
  end
endmodule

// File: rtl/audio_stream_ctrl.sv
module audio_stream_ctrl
  import asc_pkg::*;
#(
  parameter bit IS_TX = 1'b1,
  parameter int DEPTH = 4,
  parameter int LEN_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [2:0]                   cmd_code,
  input  logic                         cmd_rate_zero,
  input  logic [LEN_W-1:0]             cmd_blk_words,
  output logic                         cmd_ack,
  output logic                         cmd_err,
  input  logic                         blk_valid,
  output logic                         blk_ready,
  input  logic                         word_tick,
  output logic                         ser_en,
  output logic                         blk_done,
  output logic [$clog2(DEPTH+1)-1:0]   q_count,
  output logic [2:0]                   state
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  asc_state_e       st_q, st_d, cmd_next;
  logic             accept, reject;
  logic             drop_acc, cfg_acc, clear;
  logic             underrun, done_ev;
  logic             drain_mode;
  logic             push;
  logic [CNT_W-1:0] count;

  asc_cmd_decode #(.IS_TX(IS_TX)) u_dec (
    .state      (st_q),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .rate_zero  (cmd_rate_zero),
    .len_zero   (cmd_blk_words == '0),
    .q_nonempty (count != '0),
    .accept     (accept),
    .reject     (reject),
    .next_state (cmd_next)
  );

  assign drop_acc  = accept && (cmd_code == OP_DROP);
  assign cfg_acc   = accept && (cmd_code == OP_CONFIG);
  assign clear     = drop_acc || (cfg_acc && cmd_rate_zero);
  assign ser_en    = (st_q == ST_RUNNING) || (st_q == ST_STOPPING);
  assign blk_ready = ((st_q == ST_READY) || (st_q == ST_RUNNING)) && (count < CNT_W'(DEPTH));
  assign push      = blk_valid && blk_ready;

  asc_block_tracker #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .push     (push),
    .tick     (word_tick && ser_en),
    .load_len (cfg_acc && !cmd_rate_zero),
    .len_in   (cmd_blk_words),
    .count    (count),
    .underrun (underrun),
    .done_ev  (done_ev)
  );

  // Priority: DROP, then underrun, then other commands, then block end.
  always_comb begin
    st_d = st_q;
    if (drop_acc) begin
      st_d = ST_READY;
    end else if (underrun) begin
      st_d = ST_ERROR;
    end else if (accept) begin
      st_d = cmd_next;
    end else if (st_q == ST_STOPPING && done_ev &&
                 (!drain_mode || !IS_TX || count == CNT_W'(1))) begin
      st_d = ST_READY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_NOT_READY;
      drain_mode <= 1'b0;
      cmd_ack    <= 1'b0;
      cmd_err    <= 1'b0;
      blk_done   <= 1'b0;
    end else begin
      st_q     <= st_d;
      cmd_ack  <= accept;
      cmd_err  <= reject;
      blk_done <= done_ev && !clear;
      if (accept && (cmd_code == OP_STOP || cmd_code == OP_DRAIN)) begin
        drain_mode <= (cmd_code == OP_DRAIN);
      end
    end
  end

  assign state   = st_q;
  assign q_count = count;
endmodule

// File: rtl/asc_checker.sv
module asc_checker #(
  parameter bit IS_TX = 1'b1,
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_code,
  input logic             cmd_ack,
  input logic             cmd_err,
  input logic             blk_valid,
  input logic             blk_ready,
  input logic             word_tick,
  input logic             ser_en,
  input logic             blk_done,
  input logic [CNT_W-1:0] q_count,
  input logic [2:0]       state
);
  a_r3_ack_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ack && cmd_err));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_count) <= DEPTH);

  a_r5_push_state: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count > $past(q_count)) |-> ($past(state) == 3'd1 || $past(state) == 3'd2));

  a_r6_done_takes_block: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (int'(q_count) + 1 == int'($past(q_count)) + int'($past(blk_valid && blk_ready))));

  a_r4_start_needs_block: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_TX && state == 3'd2 && $past(state) == 3'd1) |-> ($past(q_count) != '0));

  a_r9_drop_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd4 && state != 3'd0) |=> (state == 3'd1 && q_count == '0 && !ser_en));

  a_r10_prepare_only_error: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd5 && state != 3'd4 && !ser_en) |=> ($stable(state) && cmd_err));

  a_r11_underrun_error: assert property (@(posedge clk) disable iff (!rst_n)
    (word_tick && ser_en && q_count == '0 && !(cmd_valid && cmd_code == 3'd4)) |=> (state == 3'd4));
endmodule

bind audio_stream_ctrl asc_checker #(.IS_TX(IS_TX), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .cmd_ack   (cmd_ack),
  .cmd_err   (cmd_err),
  .blk_valid (blk_valid),
  .blk_ready (blk_ready),
  .word_tick (word_tick),
  .ser_en    (ser_en),
  .blk_done  (blk_done),
  .q_count   (q_count),
  .state     (state)
);

// File: tb/audio_stream_ctrl_tb.sv
`timescale 1ns/1ps
module audio_stream_ctrl_tb;
  localparam int DEPTH = 4;
  localparam int LEN_W = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [2:0]       cmd_code = '0;
  logic             cmd_rate_zero = 1'b0;
  logic [LEN_W-1:0] cmd_blk_words = '0;
  logic             blk_valid = 1'b0;
  logic             word_tick = 1'b0;

  logic t_ack, t_err, t_rdy, t_en, t_done;
  logic r_ack, r_err, r_rdy, r_en, r_done;
  logic [CW-1:0] t_q, r_q;
  logic [2:0] t_st, r_st;

  audio_stream_ctrl #(.IS_TX(1'b1), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_rate_zero(cmd_rate_zero), .cmd_blk_words(cmd_blk_words),
    .cmd_ack(t_ack), .cmd_err(t_err), .blk_valid(blk_valid), .blk_ready(t_rdy),
    .word_tick(word_tick), .ser_en(t_en), .blk_done(t_done), .q_count(t_q), .state(t_st));

  audio_stream_ctrl #(.IS_TX(1'b0), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_dut_rx (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_rate_zero(cmd_rate_zero), .cmd_blk_words(cmd_blk_words),
    .cmd_ack(r_ack), .cmd_err(r_err), .blk_valid(blk_valid), .blk_ready(r_rdy),
    .word_tick(word_tick), .ser_en(r_en), .blk_done(r_done), .q_count(r_q), .state(r_st));

  int  vectors = 0;
  int  miscompares = 0;
  bit  use_rx = 1'b0;
  bit  finished = 1'b0;

  function automatic int o_st();   return use_rx ? int'(r_st)   : int'(t_st);   endfunction
  function automatic int o_q();    return use_rx ? int'(r_q)    : int'(t_q);    endfunction
  function automatic int o_ack();  return use_rx ? int'(r_ack)  : int'(t_ack);  endfunction
  function automatic int o_err();  return use_rx ? int'(r_err)  : int'(t_err);  endfunction
  function automatic int o_en();   return use_rx ? int'(r_en)   : int'(t_en);   endfunction
  function automatic int o_rdy();  return use_rx ? int'(r_rdy)  : int'(t_rdy);  endfunction
  function automatic int o_done(); return use_rx ? int'(r_done) : int'(t_done); endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_cmd(input logic [2:0] code, input logic rz, input int len);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_rate_zero = rz; cmd_blk_words = LEN_W'(len);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_rate_zero = 1'b0;
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); blk_valid = 1'b1;
      @(negedge clk); blk_valid = 1'b0;
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk); word_tick = 1'b1;
    repeat (n) @(negedge clk);
    word_tick = 1'b0;
  endtask

  task automatic t_reset_state();
    use_rx = 1'b0;
    do_reset();
    chk("R1", "state", o_st(), 0);
    chk("R1", "ser_en", o_en(), 0);
    chk("R1", "q_count", o_q(), 0);
    chk("R1", "ack|err", o_ack() | o_err(), 0);
    chk("R5", "blk_ready in NOT_READY", o_rdy(), 0);
  endtask

  task automatic t_configure();
    do_cmd(3'd1, 1'b0, 0);
    chk("R3", "START in NOT_READY err", o_err(), 1);
    chk("R3", "state unchanged", o_st(), 0);
    do_cmd(3'd0, 1'b0, 0);
    chk("R2", "CONFIG len 0 rejected", o_err(), 1);
    do_cmd(3'd0, 1'b0, 3);
    chk("R2", "CONFIG ack", o_ack(), 1);
    chk("R2", "state READY", o_st(), 1);
    do_cmd(3'd1, 1'b0, 0);
    chk("R4", "START empty TX rejected", o_err(), 1);
    chk("R4", "state READY", o_st(), 1);
  endtask

  task automatic t_run_and_stop();
    push_n(3);
    chk("R5", "q_count after 3 pushes", o_q(), 3);
    do_cmd(3'd1, 1'b0, 0);
    chk("R4", "START ack", o_ack(), 1);
    chk("R4", "state RUNNING", o_st(), 2);
    chk("R4", "ser_en", o_en(), 1);
    do_cmd(3'd5, 1'b0, 0);
    chk("R10", "PREPARE in RUNNING err", o_err(), 1);
    chk("R10", "state RUNNING", o_st(), 2);
    ticks(2);
    chk("R6", "no done mid-block", o_done(), 0);
    chk("R6", "q_count mid-block", o_q(), 3);
    ticks(1);
    chk("R6", "blk_done pulse", o_done(), 1);
    chk("R6", "q_count after block", o_q(), 2);
    @(negedge clk);
    chk("R6", "blk_done one cycle", o_done(), 0);
    do_cmd(3'd2, 1'b0, 0);
    chk("R7", "STOP to STOPPING", o_st(), 3);
    ticks(2);
    chk("R7", "still STOPPING mid-block", o_st(), 3);
    ticks(1);
    chk("R7", "READY at block end", o_st(), 1);
    chk("R7", "remaining blocks kept", o_q(), 1);
    ticks(2);
    chk("R6", "ticks ignored when idle", o_q(), 1);
    do_cmd(3'd1, 1'b0, 0);
    chk("R7", "resume START", o_st(), 2);
    ticks(3);
    chk("R7", "resumed block from word 0", o_done(), 1);
    chk("R7", "q_count after resumed block", o_q(), 0);
  endtask

  task automatic t_drain_tx();
    push_n(2);
    chk("R5", "push while RUNNING", o_q(), 2);
    do_cmd(3'd3, 1'b0, 0);
    chk("R8", "DRAIN to STOPPING", o_st(), 3);
    ticks(3);
    chk("R8", "TX drain continues", o_st(), 3);
    chk("R8", "q_count", o_q(), 1);
    ticks(3);
    chk("R8", "TX drain READY when empty", o_st(), 1);
    chk("R8", "q_count empty", o_q(), 0);
  endtask

  task automatic t_full_and_drop();
    push_n(4);
    chk("R5", "queue full", o_q(), 4);
    chk("R5", "blk_ready low when full", o_rdy(), 0);
    push_n(1);
    chk("R5", "extra block refused", o_q(), 4);
    do_cmd(3'd1, 1'b0, 0);
    ticks(1);
    do_cmd(3'd4, 1'b0, 0);
    chk("R9", "DROP ack", o_ack(), 1);
    chk("R9", "state READY", o_st(), 1);
    chk("R9", "q_count cleared", o_q(), 0);
    chk("R9", "ser_en off", o_en(), 0);
    push_n(1);
    do_cmd(3'd1, 1'b0, 0);
    ticks(3);
    chk("R9", "word counter cleared by DROP", o_done(), 1);
  endtask

  task automatic t_underrun();
    ticks(1);
    chk("R11", "underrun to ERROR", o_st(), 4);
    chk("R11", "ser_en off", o_en(), 0);
    chk("R5", "blk_ready low in ERROR", o_rdy(), 0);
    do_cmd(3'd1, 1'b0, 0);
    chk("R3", "START in ERROR err", o_err(), 1);
    do_cmd(3'd0, 1'b0, 3);
    chk("R2", "CONFIG in ERROR err", o_err(), 1);
    chk("R2", "state ERROR", o_st(), 4);
    do_cmd(3'd7, 1'b0, 0);
    chk("R3", "unused code err", o_err(), 1);
    do_cmd(3'd5, 1'b0, 0);
    chk("R10", "PREPARE ack", o_ack(), 1);
    chk("R10", "state READY", o_st(), 1);
    push_n(1);
    do_cmd(3'd0, 1'b1, 0);
    chk("R2", "rate zero to NOT_READY", o_st(), 0);
    chk("R2", "queue emptied", o_q(), 0);
    do_cmd(3'd4, 1'b0, 0);
    chk("R9", "DROP in NOT_READY err", o_err(), 1);
    chk("R9", "state NOT_READY", o_st(), 0);
  endtask

  task automatic t_rx_variant();
    use_rx = 1'b1;
    do_reset();
    do_cmd(3'd0, 1'b0, 2);
    do_cmd(3'd1, 1'b0, 0);
    chk("R4", "RX START with empty queue", o_st(), 2);
    ticks(1);
    chk("R11", "RX overrun to ERROR", o_st(), 4);
    do_cmd(3'd5, 1'b0, 0);
    chk("R10", "RX PREPARE", o_st(), 1);
    push_n(2);
    do_cmd(3'd1, 1'b0, 0);
    ticks(1);
    do_cmd(3'd3, 1'b0, 0);
    chk("R8", "RX DRAIN to STOPPING", o_st(), 3);
    ticks(1);
    chk("R8", "RX DRAIN ends at block", o_st(), 1);
    chk("R8", "RX block kept", o_q(), 1);
  endtask

  initial begin
    t_reset_state();
    t_configure();
    t_run_and_stop();
    t_drain_tx();
    t_full_and_drop();
    t_underrun();
    t_rx_variant();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule